// File: doc/BRIEF.md
# Byte SPI Master with Register Interface

This block is a full-duplex SPI master driven by a host through a small word-addressed register interface. The host selects a chip-select line and asserts it, programs the clock rate, clock polarity and phase, and the bit order for each direction. Each write of a byte to the transmit register then runs one 8-bit exchange on the serial pins. When the exchange ends, the received byte is held in a receive register, a ready flag is raised, and a level interrupt follows that flag through a mask.

The rate field uses an offset encoding. The half period of SCK is the field value minus a fixed offset, counted in core clocks, and small values are clamped to one clock. A timing field can move the capture of MISO one core clock past the sampling edge. This covers slaves whose data arrives late at the fastest rates, in particular with CPOL=1 and CPHA=1.

Register word addresses: 0 control, 1 configuration, 2 transmit, 3 receive, 4 cause, 5 mask, 6 timing.

Top module: `byte_spi_master`

## Requirements
- R1: Control bit 0 set drives the selected chip-select output low. Clearing it drives all chip-select outputs high.
- R2: The control field at bits [4 +: CS_W] picks which of the NCS chip-select lines is asserted. At most one line is ever low.
- R3: A transmit-register write while idle, with the length field (configuration bits [13:12]) at 0 (one byte), produces exactly 16 SCK edges and sends bits [7:0] of the written word.
- R4: When the exchange ends, the received byte reads back in receive-register bits [7:0], cause bit 0 (ready) becomes 1 and control bit 1 (busy) returns to 0.
- R5: Writing 0 to cause bit 0 clears ready. Writing 1 leaves it unchanged. Ready is set only by the end of an exchange.
- R6: With configuration bits [4:0] = P, the SCK half period is P-16 core clocks for P above 16 and one core clock otherwise.
- R7: Configuration bit 8 (CPOL) sets the SCK idle level. Configuration bit 9 (CPHA) = 0 samples MISO on the leading edge, and CPHA = 1 samples on the trailing edge. The four combinations transfer correctly.
- R8: Configuration bit 11 makes transmission LSB first, and bit 10 independently makes reception LSB first.
- R9: Timing bits [1:0] reset to 1. A value of 2 or 3 captures MISO one core clock after the sampling edge, and 0 or 1 captures on the edge.
- R10: The irq output is high exactly while cause bit 0 and mask bit 0 are both 1.
- R11: Control bit 1 reads 1 during an exchange. Transmit writes while busy, or with a non-zero length field, start nothing.
- R12: The receive register keeps its value until the next exchange ends. Reading it changes nothing.
- R13: SCK stays at the CPOL level whenever no exchange is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt, ready AND mask |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
The bench uses the default parameters: two chip selects, a 5-bit rate field with an offset of 16, and the programmable capture delay enabled. With a 5-bit field, both ends of the rate range are short enough to measure directly: a clamped value gives a one-clock half period and the field maximum gives fifteen clocks. Both chip-select lines can be exercised. Because the delay variant is built, a slave model that presents its data late can show the one-clock shift: the undelayed capture returns the byte shifted by one bit, and the delayed capture returns it intact.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

   localparam int unsigned ADDR_W    = 3;
   localparam int unsigned XFER_BITS = 8;

   localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] RA_CFG   = 3'd1;
   localparam logic [ADDR_W-1:0] RA_TX    = 3'd2;
   localparam logic [ADDR_W-1:0] RA_RX    = 3'd3;
   localparam logic [ADDR_W-1:0] RA_CAUSE = 3'd4;
   localparam logic [ADDR_W-1:0] RA_MASK  = 3'd5;
   localparam logic [ADDR_W-1:0] RA_TIME  = 3'd6;

   localparam int unsigned CTL_BUSY  = 1;
   localparam int unsigned CTL_SEL   = 4;
   localparam int unsigned CFG_CPOL  = 8;
   localparam int unsigned CFG_CPHA  = 9;
   localparam int unsigned CFG_RXLSB = 10;
   localparam int unsigned CFG_TXLSB = 11;
   localparam int unsigned CFG_LEN   = 12;
   localparam int unsigned CFG_ALEN  = 16;

   typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FIN} bsm_state_t;

   function automatic logic [XFER_BITS-1:0] flip_bits(input logic [XFER_BITS-1:0] v);
      logic [XFER_BITS-1:0] r;
      for (int i = 0; i < XFER_BITS; i++) r[i] = v[XFER_BITS-1-i];
      return r;
   endfunction

endpackage

// File: rtl/bsm_sck_gen.sv
module bsm_sck_gen #(
   parameter int unsigned PRE_W      = 5,
   parameter int unsigned PRE_OFFSET = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             cpol_i,
   input  logic [PRE_W-1:0] prescale_i,
   output logic             tick_o,
   output logic             sck_o
);
   localparam logic [PRE_W-1:0] OFF = PRE_W'(PRE_OFFSET);

   logic [PRE_W-1:0] half;
   logic [PRE_W-1:0] cnt_q;
   logic             sck_q;

   always_comb half = (prescale_i > OFF) ? (prescale_i - OFF) : PRE_W'(1);

   assign tick_o = run_i && (cnt_q == half - PRE_W'(1));
   assign sck_o  = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         sck_q <= cpol_i;
      end else if (tick_o) begin
         cnt_q <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q + PRE_W'(1);
      end
   end

   AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && $past(!run_i) && $stable(cpol_i)) |-> (sck_o == cpol_i)); // R13

endmodule

// File: rtl/bsm_shifter.sv
module bsm_shifter
   import bsm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [XFER_BITS-1:0] tx_byte_i,
   input  logic                 cpha_i,
   input  logic                 rx_lsb_i,
   input  logic                 tx_lsb_i,
   input  logic                 late_i,
   input  logic                 tick_i,
   input  logic                 miso_i,
   output logic                 busy_o,
   output logic                 run_o,
   output logic                 done_o,
   output logic [XFER_BITS-1:0] rx_byte_o,
   output logic                 mosi_o
);
   localparam int unsigned EDGES  = 2 * XFER_BITS;
   localparam int unsigned EDGE_W = $clog2(EDGES);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

   bsm_state_t           state_q;
   logic [EDGE_W-1:0]    edge_q;
   logic [XFER_BITS-1:0] tx_sh_q;
   logic [XFER_BITS-1:0] rx_sh_q;
   logic                 pend_q;
   logic                 lead, samp_edge, launch_edge;

   always_comb begin
      lead        = ~edge_q[0];
      samp_edge   = cpha_i ? ~lead : lead;
      launch_edge = cpha_i ? (lead && edge_q != '0) : ~lead;
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign run_o     = (state_q == ST_SHIFT);
   assign done_o    = (state_q == ST_FIN) && !pend_q;
   assign rx_byte_o = rx_lsb_i ? flip_bits(rx_sh_q) : rx_sh_q;
   assign mosi_o    = tx_sh_q[XFER_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         edge_q  <= '0;
         tx_sh_q <= '0;
         rx_sh_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  tx_sh_q <= tx_lsb_i ? flip_bits(tx_byte_i) : tx_byte_i;
                  edge_q  <= '0;
                  pend_q  <= 1'b0;
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (pend_q) begin
                  rx_sh_q <= {rx_sh_q[XFER_BITS-2:0], miso_i};
                  pend_q  <= 1'b0;
               end
               if (tick_i) begin
                  edge_q <= edge_q + EDGE_W'(1);
                  if (launch_edge) tx_sh_q <= {tx_sh_q[XFER_BITS-2:0], 1'b0};
                  if (samp_edge) begin
                     if (late_i) pend_q <= 1'b1;
                     else        rx_sh_q <= {rx_sh_q[XFER_BITS-2:0], miso_i};
                  end
                  if (edge_q == LAST_EDGE) state_q <= ST_FIN;
               end
            end
            default: begin
               if (pend_q) begin
                  rx_sh_q <= {rx_sh_q[XFER_BITS-2:0], miso_i};
                  pend_q  <= 1'b0;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (state_q == ST_IDLE)); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R4

endmodule

// File: rtl/bsm_regs.sv
module bsm_regs
   import bsm_pkg::*;
#(
   parameter int unsigned NCS         = 2,
   parameter int unsigned CS_W        = 1,
   parameter int unsigned PRE_W       = 5,
   parameter int unsigned DW          = 32,
   parameter bit          SAMPLE_TUNE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DW-1:0]        wdata_i,
   output logic [DW-1:0]        rdata_o,
   input  logic                 busy_i,
   input  logic                 done_i,
   input  logic [XFER_BITS-1:0] rx_byte_i,
   output logic [NCS-1:0]       cs_n_o,
   output logic                 irq_o,
   output logic                 cpol_o,
   output logic                 cpha_o,
   output logic                 rx_lsb_o,
   output logic                 tx_lsb_o,
   output logic [PRE_W-1:0]     prescale_o,
   output logic                 late_o,
   output logic                 start_o,
   output logic [XFER_BITS-1:0] tx_byte_o
);
   logic                 cs_on_q;
   logic [CS_W-1:0]      cs_sel_q;
   logic [PRE_W-1:0]     pre_q;
   logic                 cpol_q, cpha_q, rxl_q, txl_q;
   logic [1:0]           len_q, alen_q;
   logic                 ready_q, mask_q;
   logic [XFER_BITS-1:0] din_q;
   logic [1:0]           tim_q;
   logic                 unused_wdata;

   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_on_q  <= 1'b0;
         cs_sel_q <= '0;
         pre_q    <= '0;
         cpol_q   <= 1'b0;
         cpha_q   <= 1'b0;
         rxl_q    <= 1'b0;
         txl_q    <= 1'b0;
         len_q    <= '0;
         alen_q   <= '0;
         ready_q  <= 1'b0;
         mask_q   <= 1'b0;
         din_q    <= '0;
      end else begin
         if (wr_i) begin
            case (addr_i)
               RA_CTRL: begin
                  cs_on_q  <= wdata_i[0];
                  cs_sel_q <= wdata_i[CTL_SEL +: CS_W];
               end
               RA_CFG: begin
                  pre_q  <= wdata_i[PRE_W-1:0];
                  cpol_q <= wdata_i[CFG_CPOL];
                  cpha_q <= wdata_i[CFG_CPHA];
                  rxl_q  <= wdata_i[CFG_RXLSB];
                  txl_q  <= wdata_i[CFG_TXLSB];
                  len_q  <= wdata_i[CFG_LEN +: 2];
                  alen_q <= wdata_i[CFG_ALEN +: 2];
               end
               RA_CAUSE: if (!wdata_i[0]) ready_q <= 1'b0;
               RA_MASK:  mask_q <= wdata_i[0];
               default: ;
            endcase
         end
         if (done_i) begin
            ready_q <= 1'b1;
            din_q   <= rx_byte_i;
         end
      end
   end

   generate
      if (SAMPLE_TUNE) begin : g_tune
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tim_q <= 2'd1;
            else if (wr_i && addr_i == RA_TIME) tim_q <= wdata_i[1:0];
         end
         assign late_o = tim_q[1];
      end else begin : g_fixed
         assign tim_q  = 2'd1;
         assign late_o = 1'b0;
      end
   endgenerate

   for (genvar g = 0; g < NCS; g++) begin : g_cs
      assign cs_n_o[g] = ~(cs_on_q && cs_sel_q == CS_W'(g));
   end

   assign irq_o      = ready_q & mask_q;
   assign cpol_o     = cpol_q;
   assign cpha_o     = cpha_q;
   assign rx_lsb_o   = rxl_q;
   assign tx_lsb_o   = txl_q;
   assign prescale_o = pre_q;
   assign start_o    = wr_i && addr_i == RA_TX && !busy_i && len_q == 2'd0;
   assign tx_byte_o  = wdata_i[XFER_BITS-1:0];

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         RA_CTRL: begin
            rdata_o[0]               = cs_on_q;
            rdata_o[CTL_BUSY]        = busy_i;
            rdata_o[CTL_SEL +: CS_W] = cs_sel_q;
         end
         RA_CFG: begin
            rdata_o[PRE_W-1:0]    = pre_q;
            rdata_o[CFG_CPOL]     = cpol_q;
            rdata_o[CFG_CPHA]     = cpha_q;
            rdata_o[CFG_RXLSB]    = rxl_q;
            rdata_o[CFG_TXLSB]    = txl_q;
            rdata_o[CFG_LEN +: 2] = len_q;
            rdata_o[CFG_ALEN +: 2] = alen_q;
         end
         RA_RX:    rdata_o[XFER_BITS-1:0] = din_q;
         RA_CAUSE: rdata_o[0] = ready_q;
         RA_MASK:  rdata_o[0] = mask_q;
         RA_TIME:  rdata_o[1:0] = tim_q;
         default:  rdata_o = '0;
      endcase
   end

   AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> ready_q); // R4
   AST_READY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == RA_CAUSE && !wdata_i[0] && !done_i) |=> !ready_q); // R5
   AST_DIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> $stable(din_q)); // R12
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_q |-> !irq_o); // R10

endmodule

// File: rtl/byte_spi_master.sv
module byte_spi_master
   import bsm_pkg::*;
#(
   parameter int unsigned NCS         = 2,
   parameter int unsigned PRE_W       = 5,
   parameter int unsigned PRE_OFFSET  = 16,
   parameter int unsigned DW          = 32,
   parameter bit          SAMPLE_TUNE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              irq,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NCS-1:0]    spi_cs_n
);
   localparam int unsigned CS_W = (NCS > 1) ? $clog2(NCS) : 1;

   initial begin
      assert (NCS >= 2 && CS_W <= 4) else $error("NCS must be 2..16");
      assert (PRE_W <= 8 && PRE_OFFSET + 1 < (1 << PRE_W)) else $error("bad rate field");
      assert (DW >= 18) else $error("DW too narrow for the register layout");
   end

   logic                 busy, done, start, run, tick;
   logic                 cpol, cpha, rxl, txl, late;
   logic [PRE_W-1:0]     prescale;
   logic [XFER_BITS-1:0] rx_byte, tx_byte;

   bsm_regs #(
      .NCS(NCS), .CS_W(CS_W), .PRE_W(PRE_W), .DW(DW), .SAMPLE_TUNE(SAMPLE_TUNE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy), .done_i(done),
      .rx_byte_i(rx_byte), .cs_n_o(spi_cs_n), .irq_o(irq), .cpol_o(cpol),
      .cpha_o(cpha), .rx_lsb_o(rxl), .tx_lsb_o(txl), .prescale_o(prescale),
      .late_o(late), .start_o(start), .tx_byte_o(tx_byte)
   );

   bsm_sck_gen #(.PRE_W(PRE_W), .PRE_OFFSET(PRE_OFFSET)) u_sck (
      .clk(clk), .rst_n(rst_n), .run_i(run), .cpol_i(cpol),
      .prescale_i(prescale), .tick_o(tick), .sck_o(spi_sck)
   );

   bsm_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .start_i(start), .tx_byte_i(tx_byte),
      .cpha_i(cpha), .rx_lsb_i(rxl), .tx_lsb_i(txl), .late_i(late),
      .tick_i(tick), .miso_i(spi_miso), .busy_o(busy), .run_o(run),
      .done_o(done), .rx_byte_o(rx_byte), .mosi_o(spi_mosi)
   );

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~spi_cs_n)); // R2

endmodule

// File: tb/byte_spi_master_bench.sv
`timescale 1ns/1ps
module byte_spi_master_bench;
   localparam logic [2:0] A_CTRL = 0, A_CFG = 1, A_TX = 2, A_RX = 3,
                          A_CAUSE = 4, A_MASK = 5, A_TIME = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, spi_sck, spi_mosi;
   logic        miso = 1'b0;
   logic [1:0]  spi_cs_n;

   int total = 0, fails = 0, cyc = 0;

   logic       cpol_b = 0, cpha_b = 0, late_b = 0, slave_en = 0;
   logic [7:0] s_tx = 0, s_rx = 0;
   int         s_idx = -1, edges = 0;
   realtime    t_prev = 0, half_ns = 0;
   logic       lead, samp;

   always #2.5 clk = ~clk;

   byte_spi_master u_byte_spi_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(miso), .spi_cs_n(spi_cs_n)
   );

   // slave model
   always @(spi_sck) begin
      if (slave_en) begin
         edges++;
         half_ns = $realtime - t_prev;
         t_prev = $realtime;
         lead = (spi_sck != cpol_b);
         samp = cpha_b ? !lead : lead;
         #1;
         if (samp) begin
            s_rx = {s_rx[6:0], spi_mosi};
            if (late_b && s_idx >= 0) begin miso = s_tx[s_idx]; s_idx--; end
         end else if (!late_b && s_idx >= 0) begin
            miso = s_tx[s_idx]; s_idx--;
         end
      end
   end

   function automatic logic [7:0] rev8(input logic [7:0] v);
      for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_cfg(input logic pol, input logic pha, input logic rxl,
                          input logic txl, input logic [4:0] pre);
      cpol_b = pol; cpha_b = pha;
      wr(A_CFG, {20'd0, txl, rxl, pha, pol, 3'd0, pre});
      repeat (2) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] d, input logic [7:0] s, output logic [7:0] rx);
      logic [31:0] r;
      int n;
      s_rx = 0; edges = 0; s_tx = s; s_idx = 7;
      if (!cpha_b && !late_b) begin miso = s[7]; s_idx = 6; end
      else miso = 1'b0;
      slave_en = 1;
      wr(A_CAUSE, 0);
      wr(A_TX, {24'hA5A5A5, d});
      n = 0;
      do begin rd(A_CAUSE, r); n++; end while (!r[0] && n < 2000);
      rd(A_RX, r);
      rx = r[7:0];
      #2;
      slave_en = 0;
   endtask

   task automatic t_reset;
      logic [31:0] r;
      chk("R1 reset cs", {30'd0, spi_cs_n}, 32'h3);
      chk("R10 reset irq", {31'd0, irq}, 0);
      rd(A_CTRL, r); chk("R11 reset ctrl", r, 0);
      rd(A_TIME, r); chk("R9 reset timing", r, 1);
      chk("R13 reset sck", {31'd0, spi_sck}, 0);
   endtask

   task automatic t_cs;
      wr(A_CTRL, 32'h01); chk("R1 cs0 low", {30'd0, spi_cs_n}, 32'h2);
      wr(A_CTRL, 32'h11); chk("R2 cs1 low", {30'd0, spi_cs_n}, 32'h1);
      wr(A_CTRL, 32'h10); chk("R1 release", {30'd0, spi_cs_n}, 32'h3);
   endtask

   task automatic t_modes;
      logic [7:0] rx;
      logic [7:0] dv [4] = '{8'h3C, 8'h81, 8'hF0, 8'h5A};
      logic [7:0] sv [4] = '{8'hC5, 8'h12, 8'h7E, 8'hB3};
      wr(A_CTRL, 32'h01);
      for (int m = 0; m < 4; m++) begin
         set_cfg(m[1], m[0], 0, 0, 5'h12);
         xfer(dv[m], sv[m], rx);
         chk("R7 mode rx", {24'd0, rx}, {24'd0, sv[m]});
         chk("R3 mode tx", {24'd0, s_rx}, {24'd0, dv[m]});
         chk("R3 edge count", edges, 16);
         chk("R13 sck idle after", {31'd0, spi_sck}, {31'd0, cpol_b});
      end
      wr(A_CTRL, 32'h00);
   endtask

   task automatic t_order;
      logic [7:0] rx;
      set_cfg(0, 0, 1, 0, 5'h11);
      xfer(8'h13, 8'h2D, rx);
      chk("R8 rx lsb", {24'd0, rx}, {24'd0, rev8(8'h2D)});
      chk("R8 tx msb", {24'd0, s_rx}, 32'h13);
      set_cfg(1, 0, 0, 1, 5'h11);
      xfer(8'h13, 8'h2D, rx);
      chk("R8 rx msb", {24'd0, rx}, 32'h2D);
      chk("R8 tx lsb", {24'd0, s_rx}, {24'd0, rev8(8'h13)});
   endtask

   task automatic t_prescale;
      logic [7:0] rx;
      set_cfg(0, 1, 0, 0, 5'h13);
      xfer(8'h99, 8'h66, rx);
      chk("R6 half 3", int'(half_ns), 15);
      set_cfg(0, 1, 0, 0, 5'h05);
      xfer(8'h99, 8'h66, rx);
      chk("R6 clamp low", int'(half_ns), 5);
      chk("R6 clamp data", {24'd0, rx}, 32'h66);
      set_cfg(0, 1, 0, 0, 5'h1F);
      xfer(8'h99, 8'h66, rx);
      chk("R6 field max", int'(half_ns), 75);
   endtask

   task automatic t_sample;
      logic [7:0] rx;
      set_cfg(1, 1, 0, 0, 5'h11);
      late_b = 1;
      xfer(8'h00, 8'hB7, rx);
      chk("R9 late slave on edge", {24'd0, rx}, {24'd0, 8'hB7 >> 1});
      wr(A_TIME, 2);
      xfer(8'h00, 8'hB7, rx);
      chk("R9 late slave delayed", {24'd0, rx}, 32'hB7);
      late_b = 0;
      xfer(8'hE1, 8'h4C, rx);
      chk("R9 delayed normal slave", {24'd0, rx}, 32'h4C);
      wr(A_TIME, 1);
   endtask

   task automatic t_ready_irq;
      logic [7:0] rx;
      logic [31:0] r;
      set_cfg(0, 0, 0, 0, 5'h11);
      xfer(8'h01, 8'h02, rx);
      rd(A_CAUSE, r); chk("R4 ready set", r, 1);
      wr(A_MASK, 0); chk("R10 masked", {31'd0, irq}, 0);
      wr(A_MASK, 1); chk("R10 unmasked", {31'd0, irq}, 1);
      wr(A_CAUSE, 1); rd(A_CAUSE, r); chk("R5 write one keeps", r, 1);
      wr(A_CAUSE, 0); rd(A_CAUSE, r); chk("R5 write zero clears", r, 0);
      chk("R10 irq follows", {31'd0, irq}, 0);
      wr(A_CAUSE, 1); rd(A_CAUSE, r); chk("R5 write one no set", r, 0);
      wr(A_MASK, 0);
   endtask

   task automatic t_busy;
      logic [31:0] r, keep;
      int n;
      set_cfg(0, 0, 0, 0, 5'h13);
      s_rx = 0; edges = 0; s_tx = 8'h77; miso = 1'b0; s_idx = 7;
      miso = s_tx[7]; s_idx = 6;
      slave_en = 1;
      wr(A_CAUSE, 0);
      wr(A_TX, 32'h6E);
      rd(A_CTRL, r); chk("R11 busy flag", {31'd0, r[1]}, 1);
      wr(A_TX, 32'hFF);
      n = 0;
      do begin rd(A_CAUSE, r); n++; end while (!r[0] && n < 2000);
      repeat (60) @(negedge clk);
      slave_en = 0;
      chk("R11 busy write ignored", {24'd0, s_rx}, 32'h6E);
      chk("R11 single burst", edges, 16);
      rd(A_CTRL, r); chk("R4 busy cleared", {31'd0, r[1]}, 0);
      rd(A_RX, keep);
      rd(A_RX, r); chk("R12 read no effect", r, keep);
      chk("R4 rx byte", keep, 32'h77);
      // length field non-zero
      wr(A_CFG, 32'h0000_1013);
      wr(A_CAUSE, 0);
      edges = 0; slave_en = 1;
      wr(A_TX, 32'h12);
      repeat (40) @(negedge clk);
      slave_en = 0;
      chk("R11 len ignored edges", edges, 0);
      rd(A_CAUSE, r); chk("R11 len no ready", r, 0);
      rd(A_RX, r); chk("R12 rx held", r, keep);
   endtask

   task automatic t_idle;
      set_cfg(1, 0, 0, 0, 5'h11);
      chk("R13 idle high", {31'd0, spi_sck}, 1);
      set_cfg(0, 0, 0, 0, 5'h11);
      chk("R13 idle low", {31'd0, spi_sck}, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; fails++;
         $display("FAIL watchdog actual %0d expected below 150000", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_cs();
      t_modes();
      t_order();
      t_prescale();
      t_sample();
      t_ready_irq();
      t_busy();
      t_idle();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule